// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register and interrupt side of a 16550-compatible serial port. A host reaches eight byte-wide registers through a 3-bit offset, using single-cycle read and write strobes. The block holds line control, modem control, interrupt enable, scratch and a 16-bit baud divisor. It also keeps a one-byte receive holding register with data-ready and overrun flags, a modem status register with change flags, and a transmit slot. Read data is combinational from the current offset. Side effects of a read (clearing flags) take place at the clock edge that ends the read cycle.

The bit shifter is replaced by a byte handshake. A transmit write places the byte on `tx_data` and raises `tx_valid` from the next cycle. The byte is held until `tx_ready` is seen high on a clock edge. Completion arms a hidden transmit-empty interrupt flag. A read of the interrupt identification register that reports that source disarms the flag. In loopback mode, the modem status read is assembled from the modem control bits.

Top module: `serial_reg_front`

## Requirements
- R1: With line control bit 7 set, writes to offsets 0 and 1 load the low and high divisor bytes, and reads of those offsets return them. A write to offset 0 in that state starts no transmission.
- R2: With line control bit 7 clear, a write to offset 0 while the slot is idle puts the byte on `tx_data` and raises `tx_valid` from the next cycle. Line status bits 5 and 6 read 0 until an edge where `tx_valid` and `tx_ready` are both high. After that edge `tx_valid` is low, bits 5 and 6 read 1 and the transmit-empty flag is armed.
- R3: Offset 2 reads 0x04 when receive data is ready and interrupt enable bit 0 is set. Otherwise it reads 0x02 when the transmit-empty flag is armed and enable bit 1 is set. Otherwise it reads 0x01.
- R4: A read of offset 2 that returns 0x02 disarms the transmit-empty flag, so the next evaluation no longer reports it.
- R5: A read of offset 2 that returns any other code leaves the transmit-empty flag unchanged.
- R6: With modem control bit 4 set, offset 6 reads modem control bits 3:2 in bits 7:6, bit 0 in bit 5 and bit 1 in bit 4, with bits 3:0 zero.
- R7: After reset, line status reads 0x60, offset 2 reads 0x01, the interrupt enable reads 0, `irq` and `tx_valid` are low, and the divisor holds the `DIV_INIT` parameter.
- R8: Line control (8 bits), modem control (5 bits, upper bits read 0), interrupt enable (4 bits, upper bits read 0) and the scratch register at offset 7 read back what was written.
- R9: An `rx_strobe` loads `rx_byte` into the holding register and sets line status bit 0. A read of offset 0 with line control bit 7 clear clears bit 0. A strobe while bit 0 is set sets overrun bit 1, and a line status read clears bit 1.
- R10: A write to offset 0 while `tx_valid` is high is dropped, and `tx_data` keeps the pending byte.
- R11: When `rx_strobe` falls in the same cycle as a read of the holding register, the read returns the old byte. The new byte is kept with bit 0 still set and no overrun.
- R12: Outside loopback, offset 6 reads the registered modem inputs (carrier bit 7, ring bit 6, data-set-ready bit 5, clear-to-send bit 4) over change flags in bits 3:0. The flags are set on any change (ring on a falling edge only) and cleared by a read of offset 6.
- R13: `irq` is high exactly when offset 2 would read a code other than 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Interrupt request |
| tx_data | output | 8 | Byte being transmitted |
| tx_valid | output | 1 | Byte on `tx_data` awaits acceptance |
| tx_ready | input | 1 | Sink accepts the byte |
| rx_byte | input | 8 | Received byte |
| rx_strobe | input | 1 | `rx_byte` is valid this cycle |
| modem_in | input | 4 | Modem inputs {carrier, ring, data-set-ready, clear-to-send} |

## Verification
Two functions can land on the same edge: a received byte arriving while the host reads the holding register, and an overrun arriving on the same edge as a line status read. The bench drives `rx_strobe` in the very cycle of an offset-0 read. It then judges that the read returned the older byte, that line status shows data-ready without overrun, and that a follow-up read returns the new byte. A reference model runs the same collisions during a long pseudo-random phase and is compared on every clock.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int BYTE_W  = 8;
    localparam int REG_AW  = 3;
    localparam int MODEM_W = 4;
    localparam int IER_W   = 4;
    localparam int MCR_W   = 5;
    localparam int DIV_W   = 2 * BYTE_W;

    typedef enum logic [REG_AW-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_IID   = 3'd2,
        OFS_LCTL  = 3'd3,
        OFS_MCTL  = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SCR   = 3'd7
    } reg_ofs_e;

    localparam logic [BYTE_W-1:0] IID_NONE = 8'h01;
    localparam logic [BYTE_W-1:0] IID_THR  = 8'h02;
    localparam logic [BYTE_W-1:0] IID_RX   = 8'h04;

    localparam int LCTL_DIVSEL = 7;
    localparam int MCTL_LOOP   = 4;
    localparam int IEN_RX      = 0;
    localparam int IEN_THR     = 1;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    typedef struct packed {
        logic       fifo_err;
        logic       temt;
        logic       thre;
        logic [2:0] rx_err;
        logic       overrun;
        logic       ready;
    } line_stat_t;

    function automatic logic [BYTE_W-1:0] loop_status(input logic [MCR_W-1:0] mcr);
        logic [BYTE_W-1:0] r;
        r      = '0;
        r[7:6] = mcr[3:2];
        r[5]   = mcr[0];
        r[4]   = mcr[1];
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] iid_select(input logic rx_hit, input logic thr_hit);
        if (rx_hit)       return IID_RX;
        else if (thr_hit) return IID_THR;
        else              return IID_NONE;
    endfunction

endpackage

// File: rtl/sfr_tx_slot.sv
module sfr_tx_slot
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              tx_ready,
    input  logic              iid_ack,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              thr_pend
);

    logic              busy_q;
    logic              pend_q;
    logic [BYTE_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            data_q <= '0;
        end else if (busy_q) begin
            if (tx_ready) begin
                busy_q <= 1'b0;
                pend_q <= 1'b1;
            end
        end else if (load) begin
            data_q <= load_data;
            busy_q <= 1'b1;
            pend_q <= 1'b0;
        end else if (iid_ack) begin
            pend_q <= 1'b0;
        end
    end

    assign tx_valid = busy_q;
    assign tx_data  = data_q;
    assign thr_pend = pend_q;

endmodule

// File: rtl/sfr_rx_hold.sv
module sfr_rx_hold
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              hold_rd,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] hold_data,
    output logic              ready,
    output logic              overrun
);

    logic [BYTE_W-1:0] data_q;
    logic              ready_q;
    logic              ovr_q;
    logic              ovr_set;

    assign ovr_set = rx_strobe && ready_q && !hold_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (rx_strobe) begin
                data_q  <= rx_byte;
                ready_q <= 1'b1;
            end else if (hold_rd) begin
                ready_q <= 1'b0;
            end
            if (ovr_set)      ovr_q <= 1'b1;
            else if (stat_rd) ovr_q <= 1'b0;
        end
    end

    assign hold_data = data_q;
    assign ready     = ready_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/sfr_modem.sv
module sfr_modem
    import sfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  modem_lines_t       lines_in,
    input  logic [MCR_W-1:0]   mcr,
    input  logic               stat_rd,
    output logic [BYTE_W-1:0]  status
);

    modem_lines_t        lines_q;
    logic [MODEM_W-1:0]  delta_q;
    logic [MODEM_W-1:0]  change;

    always_comb begin
        change[0] = lines_in.cts ^ lines_q.cts;
        change[1] = lines_in.dsr ^ lines_q.dsr;
        change[2] = lines_q.ri & ~lines_in.ri;
        change[3] = lines_in.dcd ^ lines_q.dcd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '0;
            delta_q <= '0;
        end else begin
            lines_q <= lines_in;
            delta_q <= (stat_rd ? '0 : delta_q) | change;
        end
    end

    assign status = mcr[MCTL_LOOP] ? loop_status(mcr) : {lines_q, delta_q};

endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
    import sfr_pkg::*;
#(
    parameter logic [15:0] DIV_INIT = 16'h000C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_byte,
    input  logic              rx_strobe,
    input  logic [3:0]        modem_in
);

    reg_ofs_e          ofs;
    logic [BYTE_W-1:0] lcr_q;
    logic [IER_W-1:0]  ier_q;
    logic [MCR_W-1:0]  mcr_q;
    logic [BYTE_W-1:0] scr_q;
    logic [DIV_W-1:0]  div_q;
    logic              divsel;
    logic              thr_pend;
    logic              rx_dr;
    logic              rx_oe;
    logic [BYTE_W-1:0] rbr;
    logic [BYTE_W-1:0] msr_val;
    logic [BYTE_W-1:0] iid;
    line_stat_t        lsr;
    logic              thr_load;
    logic              iid_ack;
    logic              hold_rd;
    logic              lsr_rd;
    logic              msr_rd;

    assign ofs    = reg_ofs_e'(bus_addr);
    assign divsel = lcr_q[LCTL_DIVSEL];

    // access decode
    assign thr_load = bus_wr && (ofs == OFS_DATA) && !divsel;
    assign hold_rd  = bus_rd && (ofs == OFS_DATA) && !divsel;
    assign lsr_rd   = bus_rd && (ofs == OFS_LSTAT);
    assign msr_rd   = bus_rd && (ofs == OFS_MSTAT);
    assign iid_ack  = bus_rd && (ofs == OFS_IID) && (iid[2:0] == IID_THR[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q <= '0;
            ier_q <= '0;
            mcr_q <= '0;
            scr_q <= '0;
            div_q <= DIV_INIT;
        end else if (bus_wr) begin
            case (ofs)
                OFS_DATA: if (divsel) div_q[BYTE_W-1:0] <= bus_wdata;
                OFS_IEN: begin
                    if (divsel) div_q[DIV_W-1:BYTE_W] <= bus_wdata;
                    else        ier_q <= bus_wdata[IER_W-1:0];
                end
                OFS_LCTL: lcr_q <= bus_wdata;
                OFS_MCTL: mcr_q <= bus_wdata[MCR_W-1:0];
                OFS_SCR:  scr_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    sfr_tx_slot u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (thr_load),
        .load_data (bus_wdata),
        .tx_ready  (tx_ready),
        .iid_ack   (iid_ack),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .thr_pend  (thr_pend)
    );

    sfr_rx_hold u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_strobe (rx_strobe),
        .rx_byte   (rx_byte),
        .hold_rd   (hold_rd),
        .stat_rd   (lsr_rd),
        .hold_data (rbr),
        .ready     (rx_dr),
        .overrun   (rx_oe)
    );

    sfr_modem u_modem (
        .clk      (clk),
        .rst      (rst),
        .lines_in (modem_lines_t'(modem_in)),
        .mcr      (mcr_q),
        .stat_rd  (msr_rd),
        .status   (msr_val)
    );

    always_comb begin
        lsr          = '0;
        lsr.ready    = rx_dr;
        lsr.overrun  = rx_oe;
        lsr.thre     = !tx_valid;
        lsr.temt     = !tx_valid;
    end

    assign iid = iid_select(rx_dr && ier_q[IEN_RX], thr_pend && ier_q[IEN_THR]);
    assign irq = !iid[0];

    always_comb begin
        case (ofs)
            OFS_DATA:  bus_rdata = divsel ? div_q[BYTE_W-1:0] : rbr;
            OFS_IEN:   bus_rdata = divsel ? div_q[DIV_W-1:BYTE_W]
                                          : {{(BYTE_W-IER_W){1'b0}}, ier_q};
            OFS_IID:   bus_rdata = iid;
            OFS_LCTL:  bus_rdata = lcr_q;
            OFS_MCTL:  bus_rdata = {{(BYTE_W-MCR_W){1'b0}}, mcr_q};
            OFS_LSTAT: bus_rdata = lsr;
            OFS_MSTAT: bus_rdata = msr_val;
            default:   bus_rdata = scr_q;
        endcase
    end

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       thr_pend,
    input logic       rx_ready,
    input logic [3:0] ier,
    input logic [7:0] lcr,
    input logic [4:0] mcr
);

    p_divsel_no_tx_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && lcr[7] && !tx_valid) |=> !tx_valid);

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_tx_done_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (!tx_valid && thr_pend));

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((ier[0] && rx_ready) || (ier[1] && thr_pend)));

    p_iid_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd2 && bus_rdata[2:0] == 3'b010) |=> !thr_pend);

    p_iid_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 3'd2 && bus_rdata[2:0] == 3'b100 && thr_pend)
        |=> thr_pend);

    p_loop_map_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd6 && mcr[4])
        |-> (bus_rdata == {mcr[3:2], mcr[0], mcr[1], 4'b0000}));

    p_busy_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && bus_wr && bus_addr == 3'd0 && !lcr[7])
        |=> $stable(tx_data));

endmodule

bind serial_reg_front sfr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .thr_pend  (thr_pend),
    .rx_ready  (rx_dr),
    .ier       (ier_q),
    .lcr       (lcr_q),
    .mcr       (mcr_q)
);

// File: tb/tb_serial_reg_front.sv
module tb_serial_reg_front;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_RST    = 16'h000C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_strobe = 1'b0;
    logic [3:0] modem_in = '0;

    serial_reg_front #(.DIV_INIT(16'h000C)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_byte(rx_byte),
        .rx_strobe(rx_strobe), .modem_in(modem_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [7:0] last_rd;
    logic       nxt_rst = 1'b1;
    logic [3:0] nxt_modem = '0;

    // reference model state
    int m_lcr, m_ier, m_mcr, m_scr, m_div, m_thr, m_busy, m_pend;
    int m_rbr, m_dr, m_oe, m_lines, m_delta;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_iid();
        if (m_dr != 0 && m_ier[0])        return 4;
        else if (m_pend != 0 && m_ier[1]) return 2;
        else                              return 1;
    endfunction

    function automatic int m_read(int ofs);
        int dl = m_lcr[7];
        case (ofs)
            0: return dl ? (m_div & 255) : m_rbr;
            1: return dl ? (m_div >> 8) : m_ier;
            2: return m_iid();
            3: return m_lcr;
            4: return m_mcr;
            5: return (m_busy ? 0 : 8'h60) | (m_oe << 1) | m_dr;
            6: if (m_mcr[4])
                   return (((m_mcr >> 2) & 3) << 6) | ((m_mcr & 1) << 5) | (((m_mcr >> 1) & 1) << 4);
               else
                   return (m_lines << 4) | m_delta;
            default: return m_scr;
        endcase
    endfunction

    function automatic string tag_of(int ofs);
        case (ofs)
            0: return m_lcr[7] ? "R1" : "R9";
            1: return m_lcr[7] ? "R1" : "R8";
            2: return "R3";
            5: return "R2";
            6: return m_mcr[4] ? "R6" : "R12";
            default: return "R8";
        endcase
    endfunction

    task automatic m_reset();
        m_lcr = 0; m_ier = 0; m_mcr = 0; m_scr = 0; m_div = DIV_RST;
        m_thr = 0; m_busy = 0; m_pend = 0; m_rbr = 0; m_dr = 0; m_oe = 0;
        m_lines = 0; m_delta = 0;
    endtask

    task automatic m_step(int wr, int rd, int ofs, int wd, int stb, int byt, int rdy, int mdm);
        int dl      = m_lcr[7];
        int old_iid = m_iid();
        int hrd     = (rd && ofs == 0 && !dl);
        int ovr     = (stb && m_dr && !hrd);
        int chg;
        // transmit slot
        if (m_busy) begin
            if (rdy) begin m_busy = 0; m_pend = 1; end
        end else if (wr && ofs == 0 && !dl) begin
            m_thr = wd; m_busy = 1; m_pend = 0;
        end else if (rd && ofs == 2 && old_iid == 2) begin
            m_pend = 0;
        end
        // registers
        if (wr) begin
            case (ofs)
                0: if (dl) m_div = (m_div & 16'hFF00) | wd;
                1: if (dl) m_div = (m_div & 255) | (wd << 8); else m_ier = wd & 15;
                3: m_lcr = wd;
                4: m_mcr = wd & 31;
                7: m_scr = wd;
                default: ;
            endcase
        end
        // receive side
        if (stb) begin m_rbr = byt; m_dr = 1; end
        else if (hrd) m_dr = 0;
        if (ovr) m_oe = 1;
        else if (rd && ofs == 5) m_oe = 0;
        // modem lines
        chg = ((mdm ^ m_lines) & 4'b1011) | ((m_lines & ~mdm) & 4'b0100);
        m_delta = ((rd && ofs == 6) ? 0 : m_delta) | chg;
        m_lines = mdm;
    endtask

    task automatic tick(bit wr, bit rd, int ofs, int wd, bit stb, int byt, bit rdy);
        @(negedge clk);
        rst       = nxt_rst;
        modem_in  = nxt_modem;
        bus_wr    = wr;
        bus_rd    = rd;
        bus_addr  = ofs[2:0];
        bus_wdata = wd[7:0];
        rx_strobe = stb;
        rx_byte   = byt[7:0];
        tx_ready  = rdy;
        #(CLK_PERIOD/4);
        if (!rst) begin
            chk("R13 irq", {15'b0, irq}, (m_iid() != 1) ? 16'd1 : 16'd0);
            chk("R2 tx_valid", {15'b0, tx_valid}, m_busy[15:0]);
            chk("R2 tx_data", {8'b0, tx_data}, m_thr[15:0]);
            if (rd) chk(tag_of(ofs), {8'b0, bus_rdata}, m_read(ofs));
        end
        last_rd = bus_rdata;
        @(posedge clk);
        if (rst) m_reset();
        else m_step(wr, rd, ofs, wd, stb, byt, rdy, modem_in);
    endtask

    task automatic idle(int n, bit rdy = 1'b0);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, rdy);
    endtask
    task automatic wreg(int ofs, int v); tick(1, 0, ofs, v, 0, 0, 0); endtask
    task automatic rreg(int ofs); tick(0, 1, ofs, 0, 0, 0, 0); endtask
    task automatic rx(int v); tick(0, 0, 0, 0, 1, v, 0); endtask
    task automatic sample(); @(negedge clk); #(CLK_PERIOD/4); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lfsr = 32'h1ACE_B00C;
        m_reset();
        idle(3);
        nxt_rst = 1'b0;
        idle(1);
        // R7 reset state
        rreg(5); chk("R7 lsr", last_rd, 8'h60);
        rreg(2); chk("R7 iid", last_rd, 8'h01);
        rreg(1); chk("R7 ier", last_rd, 8'h00);
        chk("R7 irq", irq, 0); chk("R7 tx_valid", tx_valid, 0);
        // R1 divisor access
        wreg(3, 8'h80);
        rreg(0); chk("R7 div reset", last_rd, 8'h0C);
        wreg(0, 8'h34); wreg(1, 8'h12);
        rreg(0); chk("R1 div lo", last_rd, 8'h34);
        rreg(1); chk("R1 div hi", last_rd, 8'h12);
        sample(); chk("R1 no tx", tx_valid, 0);
        wreg(3, 8'h03); rreg(3); chk("R8 lcr", last_rd, 8'h03);
        wreg(1, 8'hFF); rreg(1); chk("R8 ier mask", last_rd, 8'h0F);
        wreg(1, 8'h02);
        // R2 transmit handshake, R10 drop while busy
        wreg(0, 8'h55);
        sample(); chk("R2 valid", tx_valid, 1); chk("R2 data", tx_data, 8'h55);
        rreg(5); chk("R2 lsr busy", last_rd, 8'h00);
        wreg(0, 8'h66);
        sample(); chk("R10 data kept", tx_data, 8'h55);
        idle(1, 1'b1);
        sample(); chk("R2 done", tx_valid, 0); chk("R13 irq on", irq, 1);
        rreg(5); chk("R2 lsr idle", last_rd, 8'h60);
        rreg(2); chk("R3 thr code", last_rd, 8'h02);
        sample(); chk("R4 irq off", irq, 0);
        rreg(2); chk("R4 iid none", last_rd, 8'h01);
        // R3 priority, R5 pending survives
        wreg(1, 8'h03); wreg(0, 8'h77); idle(2, 1'b1);
        rx(8'hA5);
        rreg(2); chk("R3 rx first", last_rd, 8'h04);
        rreg(0); chk("R9 rbr", last_rd, 8'hA5);
        rreg(2); chk("R5 pend kept", last_rd, 8'h02);
        rreg(2); chk("R4 cleared", last_rd, 8'h01);
        // R9 overrun
        rx(8'h11); rx(8'h22);
        rreg(5); chk("R9 overrun", last_rd, 8'h63);
        rreg(5); chk("R9 oe cleared", last_rd, 8'h61);
        rreg(0); chk("R9 newest", last_rd, 8'h22);
        rreg(5); chk("R9 dr cleared", last_rd, 8'h60);
        // R11 collision of arrival and read
        rx(8'h33);
        tick(0, 1, 0, 0, 1, 8'h44, 0); chk("R11 old byte", last_rd, 8'h33);
        rreg(5); chk("R11 dr no oe", last_rd, 8'h61);
        rreg(0); chk("R11 new byte", last_rd, 8'h44);
        // R6 loopback
        wreg(4, 8'h1F); rreg(6); chk("R6 all", last_rd, 8'hF0);
        wreg(4, 8'h15); rreg(6); chk("R6 mix a", last_rd, 8'h60);
        wreg(4, 8'h12); rreg(6); chk("R6 mix b", last_rd, 8'h10);
        rreg(4); chk("R8 mcr", last_rd, 8'h12);
        wreg(4, 8'h00);
        // R12 modem change flags
        nxt_modem = 4'b0001; idle(1);
        rreg(6); chk("R12 cts delta", last_rd, 8'h11);
        rreg(6); chk("R12 cleared", last_rd, 8'h10);
        nxt_modem = 4'b0101; idle(1);
        rreg(6); chk("R12 ri rise", last_rd, 8'h50);
        nxt_modem = 4'b0001; idle(1);
        rreg(6); chk("R12 ri fall", last_rd, 8'h14);
        wreg(7, 8'h5A); rreg(7); chk("R8 scratch", last_rd, 8'h5A);
        // pseudo-random phase against the model
        for (int n = 0; n < 2000; n++) begin
            int kind, ofs, val;
            lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04C11DB7 : 0);
            kind = (lfsr >> 3) & 7;
            ofs  = (lfsr >> 8) & 7;
            val  = (lfsr >> 12) & 255;
            if (ofs == 3) val = val & 8'h83;
            if ((lfsr >> 22) & 1) nxt_modem = (lfsr >> 24) & 15;
            case (kind)
                0, 1: tick(1, 0, ofs, val, (lfsr >> 20) & 1, val ^ 8'h5C, (lfsr >> 21) & 1);
                2, 3, 4: tick(0, 1, ofs, 0, (lfsr >> 20) & 1, val, (lfsr >> 21) & 1);
                default: tick(0, 0, 0, 0, (lfsr >> 20) & 1, val, (lfsr >> 21) & 1);
            endcase
        end
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule